// File: doc/BRIEF.md
# Typed Interrupt Source Register Bank

This block keeps the configuration word and the pending state of every interrupt source of a multiprocessor interrupt controller. Each source belongs to a class fixed at build time by its index: general-purpose, internal, or timer/inter-processor. The class decides which configuration bits software can change, which bits are held at a fixed value, and whether the source reacts to the level or to the rising edge of its input line.

Software writes one source's configuration word at a time through an indexed write port and reads any word back through an indexed combinational read port. Raw interrupt lines are sampled inside the block. A per-source acknowledge strobe clears an edge-captured request. Per-source outputs report the pending state and whether an unmasked request is present, for use by the routing and arbitration logic next to it.

Configuration word layout: bit 31 mask, bit 30 activity (read-only), bit 23 polarity, bit 22 sense, bits 19:16 priority, bits VEC_W-1:0 vector. All other bits read as zero.

Top module: `irq_src_bank`

## Requirements
- R1: Sources 0 to NUM_GEN-1 are general class, sources NUM_GEN to NUM_ORD-1 are internal class, and sources NUM_ORD to NUM_SRC-1 are timer/inter-processor class.
- R2: A write stores only bit 31 (mask), bit 23 (polarity), bit 22 (sense), bits 19:16 (priority) and bits VEC_W-1:0 (vector) of the written word; every other bit except bit 30 reads as zero.
- R3: Bit 30 (activity) cannot be written; on a read it shows the source's current pending state.
- R4: An internal-class source always reads its sense bit (22) as zero and is always level-triggered.
- R5: A timer/inter-processor source always reads its sense (22) and polarity (23) bits as zero and is always edge-triggered.
- R6: A general-class source is level-triggered when its sense bit is 1 and edge-triggered when it is 0; the mode follows the stored bit after each write and after reset.
- R7: Synchronous reset loads RST_VAL (restricted to the R2 bits, with the R4/R5 forced bits applied) into every source, and internal-class sources then also have their polarity bit set to 1; pending is cleared.
- R8: For a level-triggered source, pending equals the input line as it was two rising clock edges earlier; acknowledge has no effect.
- R9: For an edge-triggered source, a 0-to-1 change of the input makes pending 1 two rising edges after the input rises, and pending then holds until acknowledged.
- R10: An acknowledge on an edge-triggered source clears pending at the next edge, unless a new rising edge is detected at that same edge, in which case pending stays 1.
- R11: irq_act of a source is 1 exactly when that source is pending and its mask bit (31) is 0.
- R12: A read of an index at or above NUM_SRC returns all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | IDX_W | Source index for the write |
| wr_data | input | 32 | Configuration word to write |
| rd_idx | input | IDX_W | Source index for the read |
| rd_data | output | 32 | Configuration word of the read source, activity bit included |
| irq_in | input | NUM_SRC | Raw interrupt lines, one per source |
| ack | input | NUM_SRC | Acknowledge strobe, one per source |
| pending | output | NUM_SRC | Pending state, one per source |
| irq_act | output | NUM_SRC | Pending and unmasked, one per source |

## Verification
A configuration write is stored at the rising edge that samples wr_en and is visible on rd_data right after it, while a change on an interrupt line reaches pending and irq_act only after two rising edges, and an acknowledge takes effect at the single edge that samples it. The bench drives every input on the falling edge and samples on a later falling edge, after exactly the number of rising edges each result needs, so no check races the clock. The set-wins case is timed so the acknowledge is sampled at the very edge where the second input rise is detected.

// File: rtl/irq_src_pkg.sv
// Package: shared types and constants for the interrupt source bank.
// Assumes a 32-bit configuration word with the fixed field positions below.
package irq_src_pkg;

    typedef enum logic [1:0] {
        SRC_GEN = 2'd0,   // trigger mode chosen by sense bit
        SRC_INT = 2'd1,   // always level-triggered
        SRC_TIP = 2'd2    // timer / inter-processor, always edge-triggered
    } src_class_e;

    localparam int BIT_MASK = 31;
    localparam int BIT_ACT  = 30;
    localparam int BIT_POL  = 23;
    localparam int BIT_SNS  = 22;
    localparam int PRIO_LO  = 16;
    localparam int PRIO_W   = 4;

    // Maps a source index to its fixed class.
    function automatic src_class_e class_of(input int idx, input int ngen, input int nord);
        if (idx < ngen)      return SRC_GEN;
        else if (idx < nord) return SRC_INT;
        else                 return SRC_TIP;
    endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
// Module: configuration word of one interrupt source.
// Stores mask, polarity, sense, priority and vector; applies the class rules
// for forced bits at reset and on every write; derives the trigger mode.
// Assumes VEC_W <= 16 so the vector does not overlap the priority field.
module irq_cfg_reg
    import irq_src_pkg::*;
#(
    parameter src_class_e  CLASS   = SRC_GEN,
    parameter int          VEC_W   = 8,
    parameter logic [31:0] RST_VAL = 32'h8040_0005
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] cfg,
    output logic        level
);

    localparam logic [31:0] VEC_MASK = (32'd1 << VEC_W) - 32'd1;
    localparam logic [31:0] WR_MASK  = (32'd1 << BIT_MASK) | (32'd1 << BIT_POL) |
                                       (32'd1 << BIT_SNS) | (32'hF << PRIO_LO) | VEC_MASK;
    localparam logic [31:0] F_CLR    = (CLASS == SRC_INT) ? (32'd1 << BIT_SNS) :
                                       (CLASS == SRC_TIP) ? ((32'd1 << BIT_SNS) | (32'd1 << BIT_POL)) :
                                       32'd0;
    localparam logic [31:0] R_SET    = (CLASS == SRC_INT) ? (32'd1 << BIT_POL) : 32'd0;

    logic [31:0] cfg_q;

    // Holds the word: reset value with class rules, or masked software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= (RST_VAL & WR_MASK & ~F_CLR) | R_SET;
        end else if (we) begin
            cfg_q <= wdata & WR_MASK & ~F_CLR;
        end
    end

    // Trigger mode from the class, or from the sense bit for general sources.
    always_comb begin
        case (CLASS)
            SRC_INT: level = 1'b1;
            SRC_TIP: level = 1'b0;
            default: level = cfg_q[BIT_SNS];
        endcase
    end

    assign cfg = cfg_q;

    // Written mask bit lands in the word.
    p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cfg[BIT_MASK] == $past(wdata[BIT_MASK]));

    // Activity bit is never held in the stored word.
    p_act_not_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !cfg[BIT_ACT]);

    generate
        if (CLASS == SRC_INT) begin : g_int_chk
            p_int_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> (!cfg[BIT_SNS] && level));
        end else if (CLASS == SRC_TIP) begin : g_tip_chk
            p_tip_sense_pol_r5: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> (!cfg[BIT_SNS] && !cfg[BIT_POL] && !level));
        end else begin : g_gen_chk
            p_gen_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> level == $past(wdata[BIT_SNS]));
        end
    endgenerate

endmodule

// File: rtl/irq_pend_trk.sv
// Module: pending tracker of one interrupt source.
// Samples the raw line twice; level mode copies the first sample into
// pending, edge mode sets pending on a 0-to-1 between the two samples and
// clears it on acknowledge. A new edge wins over a same-cycle acknowledge.
module irq_pend_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic level,
    input  logic ack,
    output logic pend
);

    logic s1, s2, pend_q;
    logic rise;

    assign rise = s1 & ~s2;

    // Two-stage sampling of the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= irq_raw;
            s2 <= s1;
        end
    end

    // Pending update by trigger mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (level) begin
            pend_q <= s1;
        end else if (rise) begin
            pend_q <= 1'b1;
        end else if (ack) begin
            pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

    // Level mode: pending follows the raw line two edges later.
    p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level |=> pend == $past(irq_raw, 2));

    // Edge mode: detected rise sets pending.
    p_edge_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && rise) |=> pend);

    // Edge mode: acknowledge without new rise clears pending.
    p_edge_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && ack && !rise) |=> !pend);

endmodule

// File: rtl/irq_rd_mux.sv
// Module: combinational read-back of the configuration words.
// Inserts the pending state as the activity bit; out-of-range indexes
// return zero. Assumes IDX_W is wide enough to address all sources.
module irq_rd_mux
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0][31:0] cfg_all,
    input  logic [NUM_SRC-1:0]       pend_all,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [31:0]              rd_data
);

    // Select the addressed word and merge its activity bit.
    always_comb begin
        rd_data = 32'd0;
        if (32'(rd_idx) < NUM_SRC) begin
            rd_data = cfg_all[rd_idx];
            rd_data[BIT_ACT] = pend_all[rd_idx];
        end
    end

endmodule

// File: rtl/irq_src_bank.sv
// Module: top of the typed interrupt source bank.
// One configuration register and one pending tracker per source, the class
// of each fixed by its index (general, internal, timer/inter-processor).
// Assumes NUM_GEN <= NUM_ORD <= NUM_SRC and one write per cycle.
module irq_src_bank
    import irq_src_pkg::*;
#(
    parameter int          NUM_SRC = 24,
    parameter int          NUM_GEN = 16,
    parameter int          NUM_ORD = 20,
    parameter int          VEC_W   = 8,
    parameter logic [31:0] RST_VAL = 32'h8040_0005,
    localparam int         IDX_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [31:0]        wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] pending,
    output logic [NUM_SRC-1:0] irq_act
);

    logic [NUM_SRC-1:0][31:0] cfg_all;
    logic [NUM_SRC-1:0]       lvl_all;
    logic [NUM_SRC-1:0]       we_all;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            localparam src_class_e CLS = class_of(i, NUM_GEN, NUM_ORD);

            // Write decode for this source.
            assign we_all[i] = wr_en && (32'(wr_idx) == i);

            irq_cfg_reg #(
                .CLASS   (CLS),
                .VEC_W   (VEC_W),
                .RST_VAL (RST_VAL)
            ) u_cfg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we_all[i]),
                .wdata (wr_data),
                .cfg   (cfg_all[i]),
                .level (lvl_all[i])
            );

            irq_pend_trk u_pend (
                .clk     (clk),
                .rst_n   (rst_n),
                .irq_raw (irq_in[i]),
                .level   (lvl_all[i]),
                .ack     (ack[i]),
                .pend    (pending[i])
            );

            // Unmasked request output.
            assign irq_act[i] = pending[i] & ~cfg_all[i][BIT_MASK];

            // Masked sources never request.
            p_act_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_all[i][BIT_MASK] |-> !irq_act[i]);
        end
    endgenerate

    irq_rd_mux #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_rd (
        .cfg_all  (cfg_all),
        .pend_all (pending),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/irq_src_bank_bench.sv
module irq_src_bank_bench;

    localparam int          N    = 24;
    localparam int          NGEN = 16;
    localparam int          NORD = 20;
    localparam int          IW   = 5;
    localparam logic [31:0] RSTV = 32'h8040_0005;
    localparam logic [31:0] WMSK = 32'h80CF_00FF;

    // {index, write word}
    localparam logic [39:0] VECS [8] = '{
        {8'd0,  32'hFFFF_FFFF},
        {8'd15, 32'h4000_0012},
        {8'd16, 32'h80C3_0044},
        {8'd19, 32'h0040_0001},
        {8'd20, 32'h80CA_0077},
        {8'd23, 32'hFFFF_FFFF},
        {8'd7,  32'h0080_1234},
        {8'd18, 32'h7F30_FF00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  ack = '0;
    logic [N-1:0]  pending;
    logic [N-1:0]  irq_act;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_src_bank #(
        .NUM_SRC (N), .NUM_GEN (NGEN), .NUM_ORD (NORD), .VEC_W (8), .RST_VAL (RSTV)
    ) u_irq_src_bank (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
        .wr_data (wr_data), .rd_idx (rd_idx), .rd_data (rd_data),
        .irq_in (irq_in), .ack (ack), .pending (pending), .irq_act (irq_act)
    );

    // Expected word per R1, R2, R4, R5 with activity per R3.
    function automatic logic [31:0] exp_word(int idx, logic [31:0] w, logic p);
        logic [31:0] v;
        v = w & WMSK;
        if (idx >= NGEN && idx < NORD) v[22] = 1'b0;
        if (idx >= NORD) v[23:22] = 2'b00;
        v[30] = p;
        return v;
    endfunction

    // Expected reset word per R7.
    function automatic logic [31:0] exp_rst(int idx);
        logic [31:0] v;
        v = exp_word(idx, RSTV, 1'b0);
        if (idx >= NGEN && idx < NORD) v[23] = 1'b1;
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] w);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = w;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, int idx, logic [31:0] exp);
        rd_idx = IW'(idx);
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R7 reset state, R1 classes
        for (int i = 0; i < N; i++) rd_chk("R7 reset word", i, exp_rst(i));
        chk("R7 pending clear", 32'(pending), 32'd0);
        chk("R11 act clear", 32'(irq_act), 32'd0);

        // Vector table: R1 R2 R3 R4 R5
        for (int k = 0; k < 8; k++) begin
            wr(int'(VECS[k][39:32]), VECS[k][31:0]);
            rd_chk("R2 table readback", int'(VECS[k][39:32]),
                   exp_word(int'(VECS[k][39:32]), VECS[k][31:0], 1'b0));
        end

        // R12 out of range
        rd_chk("R12 out of range", 30, 32'd0);

        // R8 / R4: internal source 17 level, unmasked
        wr(17, 32'h0040_0003);
        rd_chk("R4 internal sense zero", 17, 32'h0000_0003);
        irq_in[17] = 1'b1;
        tick();
        chk("R8 not yet pending", 32'(pending[17]), 32'd0);
        tick();
        chk("R8 level pending", 32'(pending[17]), 32'd1);
        chk("R11 act unmasked", 32'(irq_act[17]), 32'd1);
        rd_chk("R3 activity reads pending", 17, 32'h4000_0003);
        ack[17] = 1'b1; tick(); ack[17] = 1'b0;
        chk("R8 ack ignored", 32'(pending[17]), 32'd1);
        irq_in[17] = 1'b0;
        tick(); tick();
        chk("R8 level drop", 32'(pending[17]), 32'd0);

        // R11 masked source
        wr(17, 32'h8000_0003);
        irq_in[17] = 1'b1; tick(); tick();
        chk("R11 masked pending", 32'(pending[17]), 32'd1);
        chk("R11 masked no act", 32'(irq_act[17]), 32'd0);
        irq_in[17] = 1'b0; tick(); tick();

        // R5 / R9 / R10: timer source 21 edge
        wr(21, 32'h00C0_0000);
        rd_chk("R5 tip sense pol zero", 21, 32'h0000_0000);
        irq_in[21] = 1'b1; tick(); tick();
        chk("R9 edge pending", 32'(pending[21]), 32'd1);
        tick();
        chk("R9 held while high", 32'(pending[21]), 32'd1);
        ack[21] = 1'b1; tick(); ack[21] = 1'b0;
        chk("R10 ack clears", 32'(pending[21]), 32'd0);
        tick();
        chk("R9 no re-trigger on held high", 32'(pending[21]), 32'd0);
        irq_in[21] = 1'b0; tick(); tick();
        irq_in[21] = 1'b1; tick(); tick();
        chk("R9 second edge", 32'(pending[21]), 32'd1);
        irq_in[21] = 1'b0; tick(); tick();
        chk("R9 held after drop", 32'(pending[21]), 32'd1);
        // R10 set wins: rise sampled at edge k, detect at edge k+1 with ack
        irq_in[21] = 1'b1; tick();
        ack[21] = 1'b1; tick(); ack[21] = 1'b0;
        chk("R10 set wins over ack", 32'(pending[21]), 32'd1);
        ack[21] = 1'b1; tick(); ack[21] = 1'b0;
        chk("R10 later ack clears", 32'(pending[21]), 32'd0);

        // R6: general source 3, level after reset (sense 1)
        irq_in[3] = 1'b1; tick(); tick();
        chk("R6 general level after reset", 32'(pending[3]), 32'd1);
        wr(3, 32'h0000_0009);
        irq_in[3] = 1'b0; tick(); tick();
        chk("R6 edge mode holds after drop", 32'(pending[3]), 32'd1);
        ack[3] = 1'b1; tick(); ack[3] = 1'b0;
        chk("R6 edge mode ack clears", 32'(pending[3]), 32'd0);
        wr(3, 32'h0040_0009);
        irq_in[3] = 1'b1; tick(); tick();
        irq_in[3] = 1'b0; tick(); tick();
        chk("R6 level mode follows drop", 32'(pending[3]), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule